// File: doc/BRIEF.md
# Read-After-Write Hazard Interlock

This block decides, once per cycle, whether the instruction sitting in decode can move on to execute. It compares each source register index of that instruction with the destination indices of the two older instructions still in flight, in execute and in memory. A dependence on a result that will exist by the time the consumer reaches execute is resolved by steering the bypass multiplexers. A dependence that cannot be met that way halts the front of the pipeline for one cycle. That case is a load still in execute whose data is not yet read.

The halt is split into two signals. The hold output freezes the program counter and the fetch/decode register. The bubble output clears the valid and write-enable bits of the decode/execute register, so a harmless empty slot travels down the pipe. Execute, memory and writeback keep moving. No filler instructions are ever needed in the program.

The bypass selects are registered. They travel with the instruction into execute, so that in its execute cycle the producer has moved one stage on.

Top module: `raw_interlock`

## Requirements
- R1: While reset is high, every bypass select reads 0 (register file) after the next clock edge.
- R2: If the execute stage holds a load (write enable high, load flag high, destination non-zero) whose destination equals any decode source, hold and bubble are both 1 in that same cycle.
- R3: A non-load in execute whose destination matches a decode source causes no hold, and on the next edge that source's select becomes 1, meaning take the memory-stage result.
- R4: A memory-stage destination matching a decode source causes no hold, and on the next edge that source's select becomes 2, meaning take the writeback-stage result.
- R5: When the execute and memory destinations both match the same source, the select becomes 1, so the younger result wins.
- R6: Register index 0 never raises hold and never produces a non-zero select.
- R7: A destination whose write enable is low never raises hold and never produces a non-zero select.
- R8: Hold and bubble are always equal. After a cycle with hold high, every select reads 0, because the slot entering execute is empty.
- R9: After a one-cycle load stall, once the load has moved to memory, hold is 0 and the dependent source gets select 2, so the stall lasts exactly one cycle.
- R10: Each source is resolved on its own: one source may bypass while the other reads the register file in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | NUM_SRC*REG_AW | Source register indices of the decode instruction |
| ex_rd | input | REG_AW | Destination index of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination index of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| hold | output | 1 | Freeze program counter and fetch/decode register |
| bubble | output | 1 | Clear valid and write enable entering execute |
| fwd_sel | output | NUM_SRC*2 | Registered bypass select per source: 0 register file, 1 memory result, 2 writeback result |

## Verification
The assertions take the stage fields to describe real in-flight instructions that stay stable between clock edges. They also assume a bubble reaches execute with its write enable already cleared, so an empty slot never looks like a writer. The bench keeps to this by changing inputs only on the falling edge. After every stall it presents the next cycle the way a real pipeline would: the load moves into the memory fields and the execute fields are emptied.

// File: rtl/raw_interlock_pkg.sv
package raw_interlock_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/ri_src_cmp.sv
// Per-source dependence check against the two older stages.
module ri_src_cmp
  import raw_interlock_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  output logic              load_use,
  output fwd_src_e          next_sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic rs_live, ex_hit, mem_hit;

  always_comb begin
    rs_live  = (rs != ZERO_REG);
    ex_hit   = rs_live && ex_wen  && (ex_rd  == rs);
    mem_hit  = rs_live && mem_wen && (mem_rd == rs);
    load_use = ex_hit && ex_is_load;
    if (ex_hit)       next_sel = FWD_MEM;
    else if (mem_hit) next_sel = FWD_WB;
    else              next_sel = FWD_RF;
  end
endmodule

// File: rtl/ri_fwd_reg.sv
// Bypass selects that travel into execute with the instruction.
module ri_fwd_reg
  import raw_interlock_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    squash,
  input  fwd_src_e [NUM_SRC-1:0]  sel_d,
  output logic [NUM_SRC-1:0][1:0] sel_q
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rst || squash) sel_q[i] <= FWD_RF;
      else               sel_q[i] <= sel_d[i];
    end
  end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
  import raw_interlock_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0]            ex_rd,
  input  logic                         ex_wen,
  input  logic                         ex_is_load,
  input  logic [REG_AW-1:0]            mem_rd,
  input  logic                         mem_wen,
  output logic                         hold,
  output logic                         bubble,
  output logic [NUM_SRC-1:0][1:0]      fwd_sel
);
  logic     [NUM_SRC-1:0] load_use;
  fwd_src_e [NUM_SRC-1:0] next_sel;
  logic                   stall;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ri_src_cmp #(.REG_AW(REG_AW)) u_cmp (
      .rs         (id_rs[s]),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .mem_rd     (mem_rd),
      .mem_wen    (mem_wen),
      .load_use   (load_use[s]),
      .next_sel   (next_sel[s])
    );
  end

  assign stall  = |load_use;
  assign hold   = stall;
  assign bubble = stall;

  ri_fwd_reg #(.NUM_SRC(NUM_SRC)) u_fwd (
    .clk    (clk),
    .rst    (rst),
    .squash (stall),
    .sel_d  (next_sel),
    .sel_q  (fwd_sel)
  );
endmodule

// File: rtl/raw_interlock_checker.sv
module raw_interlock_checker #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_SRC-1:0][REG_AW-1:0] id_rs,
  input logic [REG_AW-1:0]              ex_rd,
  input logic                           ex_wen,
  input logic                           ex_is_load,
  input logic [REG_AW-1:0]              mem_rd,
  input logic                           mem_wen,
  input logic                           hold,
  input logic                           bubble,
  input logic [NUM_SRC-1:0][1:0]        fwd_sel
);
  logic any_src_ex;
  always_comb begin
    any_src_ex = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (id_rs[i] == ex_rd) any_src_ex = 1'b1;
  end

  assert_load_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && ex_is_load && ex_rd != '0 && any_src_ex) |-> (hold && bubble));

  assert_nonload_free_R3: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load |-> !hold);

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0 && mem_rd == '0) |=> (fwd_sel == '0));

  assert_wen_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen) |=> (fwd_sel == '0 && !$past(hold)));

  assert_squash_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> (fwd_sel == '0));

  assert_pair_R8: assert property (@(posedge clk) disable iff (rst)
    hold == bubble);
endmodule

bind raw_interlock raw_interlock_checker #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .id_rs(id_rs), .ex_rd(ex_rd), .ex_wen(ex_wen),
  .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
  .hold(hold), .bubble(bubble), .fwd_sel(fwd_sel)
);

// File: tb/raw_interlock_test.sv
module raw_interlock_test;
  localparam int AW = 5;
  localparam int NS = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0][AW-1:0] id_rs = '0;
  logic [AW-1:0]     ex_rd = '0;
  logic              ex_wen = 1'b0;
  logic              ex_is_load = 1'b0;
  logic [AW-1:0]     mem_rd = '0;
  logic              mem_wen = 1'b0;
  logic              hold, bubble;
  logic [NS-1:0][1:0] fwd_sel;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  raw_interlock #(.REG_AW(AW), .NUM_SRC(NS)) uut (
    .clk(clk), .rst(rst), .id_rs(id_rs), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .hold(hold), .bubble(bubble), .fwd_sel(fwd_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on falling edge; combinational outputs are read 1 ns later
  task automatic drive(input int r0, input int r1, input int erd, input bit ew,
                       input bit ld, input int mrd, input bit mw);
    @(negedge clk);
    id_rs[0] = r0[AW-1:0]; id_rs[1] = r1[AW-1:0];
    ex_rd = erd[AW-1:0]; ex_wen = ew; ex_is_load = ld;
    mem_rd = mrd[AW-1:0]; mem_wen = mw;
    #1;
  endtask

  task automatic chk_stall(input bit exp, input string tag);
    chk(hold == exp, {tag, " hold"}, hold, exp);
    chk(bubble == exp, {tag, " bubble"}, bubble, exp);
  endtask

  // registered select, read after the next rising edge
  task automatic chk_sel(input int e0, input int e1, input string tag);
    @(posedge clk); #1;
    chk(fwd_sel[0] == e0[1:0], {tag, " sel0"}, fwd_sel[0], e0);
    chk(fwd_sel[1] == e1[1:0], {tag, " sel1"}, fwd_sel[1], e1);
  endtask

  task automatic t_reset;
    drive(3, 4, 3, 1, 0, 4, 1);
    chk_sel(0, 0, "R1");
    rst = 1'b0;
  endtask

  task automatic t_ex_bypass;
    drive(6, 12, 6, 1, 0, 0, 0);
    chk_stall(0, "R3");
    chk_sel(1, 0, "R3/R10");
  endtask

  task automatic t_mem_bypass;
    drive(2, 5, 9, 1, 0, 5, 1);
    chk_stall(0, "R4");
    chk_sel(0, 2, "R4/R10");
  endtask

  task automatic t_priority;
    drive(7, 7, 7, 1, 0, 7, 1);
    chk_stall(0, "R5");
    chk_sel(1, 1, "R5");
  endtask

  task automatic t_zero_reg;
    drive(0, 0, 0, 1, 1, 0, 1);
    chk_stall(0, "R6");
    chk_sel(0, 0, "R6");
  endtask

  task automatic t_wen_low;
    drive(4, 8, 4, 0, 1, 8, 0);
    chk_stall(0, "R7");
    chk_sel(0, 0, "R7");
  endtask

  task automatic t_load_use;
    drive(1, 9, 9, 1, 1, 0, 0);
    chk_stall(1, "R2");
    chk_sel(0, 0, "R8");
    // load has advanced to memory, execute holds the bubble
    drive(1, 9, 0, 0, 0, 9, 1);
    chk_stall(0, "R9");
    chk_sel(0, 2, "R9");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ex_bypass();
    t_mem_bypass();
    t_priority();
    t_zero_reg();
    t_wen_low();
    t_load_use();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule